// File: doc/BRIEF.md
# Lockable LRU Lookup CAM

This block is a small associative table that lets several threads sharing one processing engine find cached items and agree on who owns them. Each entry holds a key tag, a valid flag and a lock flag. A lookup compares the presented key with every valid tag at the same time. It then reports one of three outcomes: a plain hit, a hit on an entry that some thread has locked, or a miss. It also returns an entry number: the matching entry on a hit, or the least recently used entry on a miss. The caller can use that entry as the place to put the missing item.

Other commands maintain the table. A write loads a tag into a chosen entry. A lock-set or lock-clear changes one entry's lock flag. A clear-all empties the table. The lookup outcome is registered and also packed into a 6-bit word, so software-style dispatch code can branch on it directly. What the caller stores behind each entry is outside this block.

Top module: `lru_cam`

## Requirements
- R1: The table has ENTRIES entries (default 16) with KEY_W-bit tags (default 32). A lookup compares the key with all valid tags in parallel. If several valid entries match, the lowest index wins.
- R2: A lookup's result appears on the outputs in the cycle after the request, with `res_valid` high for exactly that cycle. Other commands never raise `res_valid`.
- R3: The status code is 2'b00 for miss, 2'b01 for hit and 2'b11 for locked. The code 2'b10 never appears.
- R4: On a hit or a locked result, `res_entry` is the matching entry. On a miss, it is the least recently used entry as it stood when the lookup was issued.
- R5: `res_word` is the status code in bits 5:4 and the entry number in bits 3:0.
- R6: A write (command 1) loads `req_key` into entry `req_idx`, marks it valid, clears its lock and makes it most recently used.
- R7: A lookup that hits an unlocked entry makes that entry most recently used. Miss lookups and locked lookups leave the recency order unchanged.
- R8: Lock-set (command 2) and lock-clear (command 3) set or clear the lock of entry `req_idx`. A lookup that matches a locked entry reports the locked status.
- R9: After reset, and after clear-all (command 4), every entry is invalid and unlocked, every lookup misses, and the recency order is entry 0 oldest through entry 15 newest.
- R10: Lookup is command 0. Command codes 5 to 7, and any command with `req_valid` low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command strobe |
| req_cmd | input | 3 | Command code |
| req_key | input | 32 | Lookup key or tag to write |
| req_idx | input | 4 | Target entry for write and lock commands |
| res_valid | output | 1 | Lookup result valid |
| res_status | output | 2 | Miss, hit or locked code |
| res_entry | output | 4 | Matched entry or LRU victim |
| res_word | output | 6 | Packed status and entry |

## Verification
The hardest situation to reach from the ports is a miss whose victim depends on a long and irregular history of hits and writes. Locked lookups are also part of that history, and they must not count as touches. The bench first reorders the table with directed hits and locks and checks victims it has worked out by hand. It then runs thousands of random commands over a small key pool, so hits, misses, locks and duplicate tags keep colliding. Every lookup is compared against a recency-list model kept in the bench.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;
   typedef enum logic [2:0] {
      CMD_LOOKUP = 3'd0,
      CMD_WRITE  = 3'd1,
      CMD_LOCK   = 3'd2,
      CMD_UNLOCK = 3'd3,
      CMD_CLEAR  = 3'd4
   } cam_cmd_e;

   typedef enum logic [1:0] {
      ST_MISS   = 2'b00,
      ST_HIT    = 2'b01,
      ST_LOCKED = 2'b11
   } cam_status_e;
endpackage

// File: rtl/cam_table.sv
`timescale 1ns/1ps
module cam_table #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_all,
   input  logic                     wr_en,
   input  logic                     lock_set,
   input  logic                     lock_clr,
   input  logic [IDX_W-1:0]         sel_idx,
   input  logic [KEY_W-1:0]         wr_tag,
   output logic [ENTRIES*KEY_W-1:0] tags,
   output logic [ENTRIES-1:0]       valid,
   output logic [ENTRIES-1:0]       locked
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = (sel_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n || clear_all) begin
            tags[e*KEY_W +: KEY_W] <= '0;
            valid[e]               <= 1'b0;
            locked[e]              <= 1'b0;
         end else if (sel) begin
            if (wr_en) begin
               tags[e*KEY_W +: KEY_W] <= wr_tag;
               valid[e]               <= 1'b1;
               locked[e]              <= 1'b0;
            end else if (lock_set) begin
               locked[e] <= 1'b1;
            end else if (lock_clr) begin
               locked[e] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/cam_match.sv
`timescale 1ns/1ps
module cam_match #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES*KEY_W-1:0] tags,
   input  logic [ENTRIES-1:0]       valid,
   input  logic [KEY_W-1:0]         key,
   output logic                     hit_any,
   output logic [IDX_W-1:0]         hit_idx
);
   logic [ENTRIES-1:0] hit_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = valid[e] && (tags[e*KEY_W +: KEY_W] == key);
   end

   assign hit_any = |hit_vec;

   // lowest matching index has priority
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/cam_lru.sv
`timescale 1ns/1ps
module cam_lru #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_all,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] oldest
);
   // age_q[0] is the oldest entry, age_q[ENTRIES-1] the newest
   logic [IDX_W-1:0] age_q [ENTRIES];
   logic [IDX_W-1:0] age_d [ENTRIES];
   logic [IDX_W-1:0] pos;

   always_comb begin
      pos = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (age_q[i] == touch_idx) pos = IDX_W'(i);
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) age_d[i] = age_q[i];
      if (touch_en) begin
         for (int i = 0; i < ENTRIES - 1; i++) begin
            if (i >= int'(pos)) age_d[i] = age_q[i+1];
         end
         age_d[ENTRIES-1] = touch_idx;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (!rst_n || clear_all) age_q[i] <= IDX_W'(i);
         else                     age_q[i] <= age_d[i];
      end
   end

   assign oldest = age_q[0];
endmodule

// File: rtl/lru_cam.sv
`timescale 1ns/1ps
module lru_cam
   import cam_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int WORD_W = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [KEY_W-1:0]  req_key,
   input  logic [IDX_W-1:0]  req_idx,
   output logic              res_valid,
   output logic [1:0]        res_status,
   output logic [IDX_W-1:0]  res_entry,
   output logic [WORD_W-1:0] res_word
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("lru_cam: ENTRIES must be a power of two and at least 2");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("lru_cam: KEY_W must be positive");
   end

   logic do_lookup, do_write, do_lock, do_unlock, do_clear;
   assign do_lookup = req_valid && (req_cmd == CMD_LOOKUP);
   assign do_write  = req_valid && (req_cmd == CMD_WRITE);
   assign do_lock   = req_valid && (req_cmd == CMD_LOCK);
   assign do_unlock = req_valid && (req_cmd == CMD_UNLOCK);
   assign do_clear  = req_valid && (req_cmd == CMD_CLEAR);

   logic [ENTRIES*KEY_W-1:0] tags;
   logic [ENTRIES-1:0]       valid, locked;
   logic                     hit_any;
   logic [IDX_W-1:0]         hit_idx, oldest;
   logic                     hit_locked;

   cam_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_table (
      .clk(clk), .rst_n(rst_n), .clear_all(do_clear),
      .wr_en(do_write), .lock_set(do_lock), .lock_clr(do_unlock),
      .sel_idx(req_idx), .wr_tag(req_key),
      .tags(tags), .valid(valid), .locked(locked)
   );

   cam_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
      .tags(tags), .valid(valid), .key(req_key),
      .hit_any(hit_any), .hit_idx(hit_idx)
   );

   assign hit_locked = locked[hit_idx];

   logic             touch_en;
   logic [IDX_W-1:0] touch_idx;
   assign touch_en  = do_write || (do_lookup && hit_any && !hit_locked);
   assign touch_idx = do_write ? req_idx : hit_idx;

   cam_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .clear_all(do_clear),
      .touch_en(touch_en), .touch_idx(touch_idx), .oldest(oldest)
   );

   cam_status_e st_d;
   always_comb begin
      if (!hit_any)        st_d = ST_MISS;
      else if (hit_locked) st_d = ST_LOCKED;
      else                 st_d = ST_HIT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_status <= ST_MISS;
         res_entry  <= '0;
      end else begin
         res_valid <= do_lookup;
         if (do_lookup) begin
            res_status <= st_d;
            res_entry  <= hit_any ? hit_idx : oldest;
         end
      end
   end

   assign res_word = {res_status, res_entry};
endmodule

// File: rtl/cam_checks.sv
`timescale 1ns/1ps
module cam_checks #(
   parameter int KEY_W = 32,
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       req_cmd,
   input logic [KEY_W-1:0] req_key,
   input logic             res_valid,
   input logic [1:0]       res_status,
   input logic [IDX_W-1:0] res_entry
);
   a_r2_result_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(req_valid && req_cmd == 3'd0));

   a_r2_lookup_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 3'd0) |=> res_valid);

   a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_status != 2'b10));

   a_r9_clear_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 3'd0 && $past(req_valid && req_cmd == 3'd4))
      |=> (res_status == 2'b00));

   a_r6_written_key_found: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 3'd0 && $past(req_valid && req_cmd == 3'd1)
       && req_key == $past(req_key))
      |=> (res_status != 2'b00));
endmodule

bind lru_cam cam_checks #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_cam_checks (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
   .req_key(req_key), .res_valid(res_valid), .res_status(res_status),
   .res_entry(res_entry)
);

// File: tb/test_lru_cam.sv
`timescale 1ns/1ps
module test_lru_cam;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_cmd = '0;
   logic [31:0] req_key = '0;
   logic [3:0]  req_idx = '0;
   logic        res_valid;
   logic [1:0]  res_status;
   logic [3:0]  res_entry;
   logic [5:0]  res_word;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   lru_cam i_lru_cam (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_key(req_key), .req_idx(req_idx), .res_valid(res_valid),
      .res_status(res_status), .res_entry(res_entry), .res_word(res_word)
   );

   always #5 clk = ~clk;

   // reference model
   logic [31:0] m_tag [16];
   bit          m_v   [16];
   bit          m_l   [16];
   int          m_ord [16];
   int          last_st, last_en;

   function automatic void m_reset();
      for (int i = 0; i < 16; i++) begin
         m_tag[i] = '0; m_v[i] = 0; m_l[i] = 0; m_ord[i] = i;
      end
   endfunction

   function automatic void m_touch(int e);
      int p = 0;
      for (int i = 0; i < 16; i++) if (m_ord[i] == e) p = i;
      for (int i = p; i < 15; i++) m_ord[i] = m_ord[i+1];
      m_ord[15] = e;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // drive one command at a negedge, sample one cycle later at the next negedge
   task automatic do_cmd(int cmd, logic [31:0] key, int idx);
      int exp_st = 0, exp_en = 0, hit = -1;
      req_valid = 1; req_cmd = cmd[2:0]; req_key = key; req_idx = idx[3:0];
      case (cmd)
         0: begin
            for (int i = 15; i >= 0; i--) if (m_v[i] && m_tag[i] == key) hit = i;
            if (hit < 0) begin exp_st = 0; exp_en = m_ord[0]; end
            else if (m_l[hit]) begin exp_st = 3; exp_en = hit; end
            else begin exp_st = 1; exp_en = hit; m_touch(hit); end
         end
         1: begin m_tag[idx] = key; m_v[idx] = 1; m_l[idx] = 0; m_touch(idx); end
         2: m_l[idx] = 1;
         3: m_l[idx] = 0;
         4: m_reset();
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      if (cmd == 0) begin
         check(res_valid == 1'b1, "R2 res_valid after lookup", res_valid, 1);
         check(res_status == exp_st[1:0], "R3/R4/R7/R8 status", res_status, exp_st);
         check(res_entry == exp_en[3:0], "R4/R7 entry", res_entry, exp_en);
         check(res_word == {exp_st[1:0], exp_en[3:0]}, "R5 packed word", res_word,
               {exp_st[1:0], exp_en[3:0]});
         last_st = res_status; last_en = res_entry;
      end else begin
         check(res_valid == 1'b0, "R2 no result for non-lookup", res_valid, 0);
      end
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1c5a_77e1));
      m_reset();
      repeat (3) @(negedge clk);
      check(res_valid == 0 && res_word == 0, "R9 reset outputs", res_word, 0);
      rst_n = 1;
      @(negedge clk);

      // R9: empty table misses and names entry 0 as victim
      do_cmd(0, 32'hDEAD, 0);
      check(last_st == 0 && last_en == 0, "R9 empty miss victim", last_en, 0);

      // R6: fill every entry
      for (int i = 0; i < 16; i++) do_cmd(1, 32'd100 + i, i);
      do_cmd(0, 32'd103, 0);
      check(last_st == 1 && last_en == 3, "R4 hit entry 3", last_en, 3);
      do_cmd(0, 32'd7, 0);
      check(last_st == 0 && last_en == 0, "R7 victim entry 0", last_en, 0);
      do_cmd(0, 32'd100, 0);
      do_cmd(0, 32'd7, 0);
      check(last_en == 1, "R7 hit on 0 moves victim to 1", last_en, 1);

      // R8: lock and unlock
      do_cmd(2, 0, 1);
      do_cmd(0, 32'd101, 0);
      check(last_st == 3 && last_en == 1, "R8 locked status", last_st, 3);
      do_cmd(0, 32'd7, 0);
      check(last_en == 1, "R7 locked lookup keeps order", last_en, 1);
      do_cmd(3, 0, 1);
      do_cmd(0, 32'd101, 0);
      check(last_st == 1, "R8 unlock gives hit", last_st, 1);

      // R1: duplicate tag, lowest index wins
      do_cmd(1, 32'd109, 4);
      do_cmd(0, 32'd109, 0);
      check(last_en == 4, "R1 lowest index wins", last_en, 4);

      // R6: write clears lock
      do_cmd(2, 0, 9);
      do_cmd(1, 32'd209, 9);
      do_cmd(0, 32'd209, 0);
      check(last_st == 1 && last_en == 9, "R6 write clears lock", last_st, 1);

      // R10: unknown command and valid low change nothing
      do_cmd(7, 32'd300, 2);
      do_cmd(0, 32'd102, 0);
      check(last_st == 1 && last_en == 2, "R10 bogus command ignored", last_en, 2);
      req_cmd = 3'd1; req_key = 32'd500; req_idx = 4'd6;
      @(negedge clk);
      do_cmd(0, 32'd500, 0);
      check(last_st == 0, "R10 valid low write ignored", last_st, 0);
      do_cmd(0, 32'd106, 0);
      check(last_st == 1 && last_en == 6, "R10 entry 6 intact", last_en, 6);

      // R9: clear-all
      do_cmd(4, 0, 0);
      do_cmd(0, 32'd100, 0);
      check(last_st == 0 && last_en == 0, "R9 clear-all misses", last_en, 0);

      // random traffic over a small key pool
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom_range(99);
         int c;
         if (r < 50)      c = 0;
         else if (r < 75) c = 1;
         else if (r < 85) c = 2;
         else if (r < 95) c = 3;
         else if (r < 97) c = 4;
         else             c = 5 + $urandom_range(2);
         do_cmd(c, 32'd1000 + $urandom_range(23), $urandom_range(15));
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule